// File: doc/BRIEF.md
# Register-Pair ALU with Condition Flags

This block is the single-cycle arithmetic and logic unit for two-operand register instructions. A 4-bit operation code picks one of sixteen functions applied to a destination operand and a source operand. The block produces a 32-bit result, a write-enable that tells the register file whether to keep that result, and a fresh set of negative, zero, carry and overflow flags. It is purely combinational, including the multiply, so a pipeline stage can place it between operand read and write-back with no handshake.

Every operation recomputes the negative and zero flags, so only the incoming carry and overflow flags are inputs. Three operations (bitwise test, compare, compare-by-add) exist only to set flags. For them the result port still carries the value the flags were computed from, but the write-enable is low. Carry and overflow are either produced by the adder, produced by the shifter, or passed through unchanged, depending on the operation.

Top module: `pairop_alu`

## Requirements
- R1: The bitwise codes give: 0000 D AND S, 0001 D XOR S, 1100 D OR S, 1110 D AND NOT S, and 1111 NOT S. Here D is `opnd_d` and S is `opnd_s`.
- R2: Code 0101 gives D + S + C. Code 0110 gives D − S − (1 − C), where C is `c_in`. For these, `c_out` is the carry out of the addition (for the subtraction it means "no borrow"), and `v_out` is set exactly when the true signed result does not fit in 32 bits.
- R3: Codes 1000 (flags of D AND S), 1010 (flags of D − S) and 1011 (flags of D + S) drive `result_we` low. All other codes drive it high. For these three codes `result` carries the value the flags describe. Compare and compare-by-add set C and V as in R2.
- R4: Code 1001 gives 0 − S. `c_out` is set only when S is zero, and `v_out` is set only when S is 0x80000000.
- R5: Code 1101 gives the low 32 bits of S × D.
- R6: For the shift and rotate codes (0010 left, 0011 logical right, 0100 arithmetic right, 0111 rotate right), the amount is S[7:0] only. An amount of zero returns D unchanged and passes `c_in` to `c_out`.
- R7: A left or logical-right shift by 1 to 31 sets `c_out` to the last bit shifted out. A shift by exactly 32 gives 0, with `c_out` equal to D[0] for a left shift or D[31] for a logical-right shift. A shift by 33 to 255 gives 0 and clears `c_out`.
- R8: An arithmetic right shift by 1 to 31 sets `c_out` to the last bit shifted out. An amount of 32 or more fills every result bit, and `c_out`, with D[31].
- R9: A nonzero rotate amount rotates D right by the amount modulo 32, and `c_out` equals result bit 31. This includes multiples of 32, which return D.
- R10: For every code, `n_out` equals result bit 31 and `z_out` is set exactly when the result is zero.
- R11: The bitwise codes (including 1000) and the multiply pass `c_in` and `v_in` to `c_out` and `v_out`. The shift and rotate codes pass `v_in` to `v_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| opnd_d | input | 32 | Destination-register operand (first operand) |
| opnd_s | input | 32 | Source-register operand (second operand, shift amount) |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| result | output | 32 | Computed value |
| result_we | output | 1 | High when the result is to be written back |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |
| v_out | output | 1 | New overflow flag |

## Verification
The hardest cases to reach from the ports are the shift boundaries. These are amounts of exactly 32, amounts above 32, and source words whose low byte is zero while their upper bits are not. Uniform random operands almost never land there. The stimulus therefore sends the source operand through a biased picker that keeps random upper bits but draws the low byte from 0 to 40 or from its full range, and it adds directed vectors for each boundary. The carry-in cases for subtract-with-carry with equal operands and both carry values get directed vectors as well, since they separate the borrow convention from a plain subtract.

// File: rtl/pairop_pkg.sv
package pairop_pkg;

    typedef enum logic [3:0] {
        OP_AND     = 4'h0,
        OP_XOR     = 4'h1,
        OP_SHL     = 4'h2,
        OP_SHR     = 4'h3,
        OP_SAR     = 4'h4,
        OP_ADDC    = 4'h5,
        OP_SUBC    = 4'h6,
        OP_ROTR    = 4'h7,
        OP_TESTAND = 4'h8,
        OP_NEG     = 4'h9,
        OP_CMPSUB  = 4'hA,
        OP_CMPADD  = 4'hB,
        OP_OR      = 4'hC,
        OP_MUL     = 4'hD,
        OP_ANDN    = 4'hE,
        OP_NOT     = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {SRC_BITWISE, SRC_SHIFT, SRC_ARITH, SRC_MUL} res_src_e;
    typedef enum logic [2:0] {BW_AND, BW_XOR, BW_OR, BW_ANDN, BW_NOT} bitwise_fn_e;
    typedef enum logic [1:0] {SH_LEFT, SH_RIGHT, SH_ARITH, SH_ROT} shift_fn_e;
    typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} carry_sel_e;

    typedef struct packed {
        res_src_e    src;
        bitwise_fn_e bfn;
        shift_fn_e   sfn;
        logic        zero_a;
        logic        invert_b;
        carry_sel_e  cin;
        logic        write;
        logic        upd_c;
        logic        upd_v;
    } alu_ctl_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic is_shift(alu_op_e op);
        return op inside {OP_SHL, OP_SHR, OP_SAR, OP_ROTR};
    endfunction

    function automatic logic is_flag_only(alu_op_e op);
        return op inside {OP_TESTAND, OP_CMPSUB, OP_CMPADD};
    endfunction

    function automatic logic carry_bit(carry_sel_e sel, logic flag_c);
        case (sel)
            CIN_ONE:  return 1'b1;
            CIN_FLAG: return flag_c;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic bitwise_bit(bitwise_fn_e fn, logic a, logic b);
        case (fn)
            BW_XOR:  return a ^ b;
            BW_OR:   return a | b;
            BW_ANDN: return a & ~b;
            BW_NOT:  return ~b;
            default: return a & b;
        endcase
    endfunction

endpackage

// File: rtl/pairop_decode.sv
module pairop_decode
    import pairop_pkg::*;
(
    input  logic [3:0] op_code,
    output alu_ctl_t   ctl
);

    alu_op_e op;
    assign op = alu_op_e'(op_code);

    always_comb begin
        ctl = '{src: SRC_BITWISE, bfn: BW_AND, sfn: SH_LEFT, zero_a: 1'b0,
                invert_b: 1'b0, cin: CIN_ZERO, write: 1'b1, upd_c: 1'b0,
                upd_v: 1'b0};
        case (op)
            OP_AND:     ctl.bfn = BW_AND;
            OP_XOR:     ctl.bfn = BW_XOR;
            OP_OR:      ctl.bfn = BW_OR;
            OP_ANDN:    ctl.bfn = BW_ANDN;
            OP_NOT:     ctl.bfn = BW_NOT;
            OP_TESTAND: begin
                ctl.bfn   = BW_AND;
                ctl.write = 1'b0;
            end
            OP_SHL, OP_SHR, OP_SAR, OP_ROTR: begin
                ctl.src   = SRC_SHIFT;
                ctl.upd_c = 1'b1;
                case (op)
                    OP_SHL:  ctl.sfn = SH_LEFT;
                    OP_SHR:  ctl.sfn = SH_RIGHT;
                    OP_SAR:  ctl.sfn = SH_ARITH;
                    default: ctl.sfn = SH_ROT;
                endcase
            end
            OP_ADDC: begin
                ctl.src   = SRC_ARITH;
                ctl.cin   = CIN_FLAG;
                ctl.upd_c = 1'b1;
                ctl.upd_v = 1'b1;
            end
            OP_SUBC: begin
                ctl.src      = SRC_ARITH;
                ctl.invert_b = 1'b1;
                ctl.cin      = CIN_FLAG;
                ctl.upd_c    = 1'b1;
                ctl.upd_v    = 1'b1;
            end
            OP_NEG: begin
                ctl.src      = SRC_ARITH;
                ctl.zero_a   = 1'b1;
                ctl.invert_b = 1'b1;
                ctl.cin      = CIN_ONE;
                ctl.upd_c    = 1'b1;
                ctl.upd_v    = 1'b1;
            end
            OP_CMPSUB: begin
                ctl.src      = SRC_ARITH;
                ctl.invert_b = 1'b1;
                ctl.cin      = CIN_ONE;
                ctl.write    = 1'b0;
                ctl.upd_c    = 1'b1;
                ctl.upd_v    = 1'b1;
            end
            OP_CMPADD: begin
                ctl.src   = SRC_ARITH;
                ctl.write = 1'b0;
                ctl.upd_c = 1'b1;
                ctl.upd_v = 1'b1;
            end
            OP_MUL:     ctl.src = SRC_MUL;
            default:    ctl.bfn = BW_AND;
        endcase
    end

endmodule

// File: rtl/pairop_adder.sv
module pairop_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         zero_a,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    localparam int MSB = W - 1;

    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;
    logic [W:0]   total;

    always_comb begin
        a_eff = zero_a ? '0 : a;
        b_eff = invert_b ? ~b : b;
        total = {1'b0, a_eff} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    end

    assign sum  = total[MSB:0];
    assign cout = total[W];
    // Signed overflow: both addends share a sign that the sum does not.
    assign ovf  = (a_eff[MSB] == b_eff[MSB]) && (sum[MSB] != a_eff[MSB]);

endmodule

// File: rtl/pairop_shifter.sv
module pairop_shifter
    import pairop_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     val,
    input  logic [AMT_W-1:0] amt,
    input  shift_fn_e        fn,
    input  logic             c_in,
    output logic [W-1:0]     res,
    output logic             cout
);

    localparam int                 ROT_W = $clog2(W);
    localparam int                 MSB   = W - 1;
    localparam logic [AMT_W-1:0]   FULL  = AMT_W'(W);

    logic                 over;
    logic [AMT_W-1:0]     sat_amt;
    logic [W:0]           lsl_t;
    logic [W:0]           lsr_t;
    logic signed [W:0]    asr_in;
    logic signed [W:0]    asr_t;
    logic [ROT_W-1:0]     rot_n;
    logic [W-1:0]         rot_t;

    // Each wide variant keeps one extra bit that catches the last bit out.
    always_comb begin
        over    = amt > FULL;
        sat_amt = over ? FULL : amt;
        lsl_t   = over ? '0 : ({1'b0, val} << amt);
        lsr_t   = over ? '0 : ({val, 1'b0} >> amt);
        asr_in  = {val, 1'b0};
        asr_t   = asr_in >>> sat_amt;
        rot_n   = amt[ROT_W-1:0];
        rot_t   = W'({val, val} >> rot_n);
    end

    always_comb begin
        if (amt == '0) begin
            res  = val;
            cout = c_in;
        end else begin
            case (fn)
                SH_LEFT: begin
                    res  = lsl_t[MSB:0];
                    cout = lsl_t[W];
                end
                SH_RIGHT: begin
                    res  = lsr_t[W:1];
                    cout = lsr_t[0];
                end
                SH_ARITH: begin
                    res  = asr_t[W:1];
                    cout = asr_t[0];
                end
                default: begin
                    res  = rot_t;
                    cout = rot_t[MSB];
                end
            endcase
        end
    end

endmodule

// File: rtl/pairop_bitwise.sv
module pairop_bitwise
    import pairop_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  bitwise_fn_e  fn,
    output logic [W-1:0] y
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = bitwise_bit(fn, a[i], b[i]);
    end

endmodule

// File: rtl/pairop_alu.sv
module pairop_alu
    import pairop_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [3:0]   op_code,
    input  logic [W-1:0] opnd_d,
    input  logic [W-1:0] opnd_s,
    input  logic         c_in,
    input  logic         v_in,
    output logic [W-1:0] result,
    output logic         result_we,
    output logic         n_out,
    output logic         z_out,
    output logic         c_out,
    output logic         v_out
);

    localparam int MSB = W - 1;

    alu_ctl_t     ctl;
    logic [W-1:0] bw_y;
    logic [W-1:0] sh_y;
    logic         sh_c;
    logic [W-1:0] add_y;
    logic         add_c;
    logic         add_v;
    logic [W-1:0] mul_y;
    logic         add_cin;
    flags_t       fl;

    pairop_decode u_decode (
        .op_code (op_code),
        .ctl     (ctl)
    );

    pairop_bitwise #(.W(W)) u_bitwise (
        .a  (opnd_d),
        .b  (opnd_s),
        .fn (ctl.bfn),
        .y  (bw_y)
    );

    pairop_shifter #(.W(W), .AMT_W(AMT_W)) u_shifter (
        .val  (opnd_d),
        .amt  (opnd_s[AMT_W-1:0]),
        .fn   (ctl.sfn),
        .c_in (c_in),
        .res  (sh_y),
        .cout (sh_c)
    );

    assign add_cin = carry_bit(ctl.cin, c_in);

    pairop_adder #(.W(W)) u_adder (
        .a        (opnd_d),
        .b        (opnd_s),
        .zero_a   (ctl.zero_a),
        .invert_b (ctl.invert_b),
        .cin      (add_cin),
        .sum      (add_y),
        .cout     (add_c),
        .ovf      (add_v)
    );

    // Single-cycle multiply, low word only.
    assign mul_y = opnd_s * opnd_d;

    always_comb begin
        case (ctl.src)
            SRC_SHIFT: result = sh_y;
            SRC_ARITH: result = add_y;
            SRC_MUL:   result = mul_y;
            default:   result = bw_y;
        endcase
    end

    always_comb begin
        fl.n = result[MSB];
        fl.z = (result == '0);
        if (ctl.upd_c)
            fl.c = (ctl.src == SRC_SHIFT) ? sh_c : add_c;
        else
            fl.c = c_in;
        fl.v = ctl.upd_v ? add_v : v_in;
    end

    assign result_we = ctl.write;
    assign n_out     = fl.n;
    assign z_out     = fl.z;
    assign c_out     = fl.c;
    assign v_out     = fl.v;

endmodule

// File: rtl/pairop_alu_chk.sv
module pairop_alu_chk
    import pairop_pkg::*;
#(
    parameter int W = 32
) (
    input logic [3:0]   op_code,
    input logic [W-1:0] opnd_d,
    input logic [W-1:0] opnd_s,
    input logic         c_in,
    input logic         v_in,
    input logic [W-1:0] result,
    input logic         result_we,
    input logic         n_out,
    input logic         z_out,
    input logic         c_out,
    input logic         v_out
);

    alu_op_e op;
    assign op = alu_op_e'(op_code);

    always_comb begin
        a_r3_write_gate: assert (result_we == !is_flag_only(op))
            else $error("R3 write-enable wrong for op %h", op_code);

        a_r10_n_z_track: assert (n_out == result[W-1] && z_out == (result == '0))
            else $error("R10 N/Z disagree with result");

        if (op inside {OP_AND, OP_XOR, OP_OR, OP_ANDN, OP_NOT, OP_TESTAND, OP_MUL}) begin
            a_r11_cv_hold: assert (c_out == c_in && v_out == v_in)
                else $error("R11 C/V changed by op %h", op_code);
        end

        if (is_shift(op)) begin
            a_r11_v_shift: assert (v_out == v_in)
                else $error("R11 V changed by shift");
        end

        if (is_shift(op) && opnd_s[7:0] == 8'd0) begin
            a_r6_zero_amount: assert (result == opnd_d && c_out == c_in)
                else $error("R6 zero amount altered value or carry");
        end

        if (op == OP_SAR && opnd_s[7:0] >= 8'(W)) begin
            a_r8_sign_fill: assert (result == {W{opnd_d[W-1]}} && c_out == opnd_d[W-1])
                else $error("R8 wide arithmetic shift not sign filled");
        end

        if (op == OP_NEG) begin
            a_r4_neg_carry: assert (c_out == (opnd_s == '0))
                else $error("R4 negate carry wrong");
        end
    end

endmodule

bind pairop_alu pairop_alu_chk #(.W(W)) u_pairop_alu_chk (
    .op_code   (op_code),
    .opnd_d    (opnd_d),
    .opnd_s    (opnd_s),
    .c_in      (c_in),
    .v_in      (v_in),
    .result    (result),
    .result_we (result_we),
    .n_out     (n_out),
    .z_out     (z_out),
    .c_out     (c_out),
    .v_out     (v_out)
);

// File: tb/test_pairop_alu.sv
module test_pairop_alu;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [3:0]  op_code = 4'h0;
    logic [31:0] opnd_d  = 32'h0;
    logic [31:0] opnd_s  = 32'h0;
    logic        c_in    = 1'b0;
    logic        v_in    = 1'b0;
    logic [31:0] result;
    logic        result_we, n_out, z_out, c_out, v_out;

    int checks = 0;
    int errors = 0;

    pairop_alu i_pairop_alu (
        .op_code   (op_code),
        .opnd_d    (opnd_d),
        .opnd_s    (opnd_s),
        .c_in      (c_in),
        .v_in      (v_in),
        .result    (result),
        .result_we (result_we),
        .n_out     (n_out),
        .z_out     (z_out),
        .c_out     (c_out),
        .v_out     (v_out)
    );

    function automatic bit too_wide(longint e);
        return (e > 64'sd2147483647) || (e < -64'sd2147483648);
    endfunction

    // Behavioural reference: 64-bit integer arithmetic and bit-at-a-time shifts.
    task automatic ref_model(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                             input logic c, input logic v, output logic [31:0] r,
                             output logic we, output logic nn, output logic zz,
                             output logic cc, output logic vv);
        longint unsigned ud, us, t;
        longint sd, ss;
        int amt;
        logic [31:0] x;
        ud = longint'(d); us = longint'(s);
        sd = longint'($signed(d)); ss = longint'($signed(s));
        amt = int'(s[7:0]);
        r = '0; we = 1'b1; cc = c; vv = v; x = d;
        case (op)
            4'h0: r = d & s;
            4'h1: r = d ^ s;
            4'hC: r = d | s;
            4'hE: r = d & ~s;
            4'hF: r = ~s;
            4'h8: begin r = d & s; we = 1'b0; end
            4'hD: begin t = ud * us; r = t[31:0]; end
            4'h5: begin
                t = ud + us + (c ? 1 : 0); r = t[31:0]; cc = t > 64'hFFFF_FFFF;
                vv = too_wide(sd + ss + (c ? 1 : 0));
            end
            4'h6: begin
                t = ud - us - (c ? 0 : 1); r = t[31:0]; cc = ud >= us + (c ? 0 : 1);
                vv = too_wide(sd - ss - (c ? 0 : 1));
            end
            4'hA: begin
                t = ud - us; r = t[31:0]; cc = ud >= us; vv = too_wide(sd - ss); we = 1'b0;
            end
            4'hB: begin
                t = ud + us; r = t[31:0]; cc = t > 64'hFFFF_FFFF; vv = too_wide(sd + ss);
                we = 1'b0;
            end
            4'h9: begin t = 0 - us; r = t[31:0]; cc = (us == 0); vv = too_wide(-ss); end
            4'h2: begin
                for (int k = 0; k < amt; k++) begin cc = x[31]; x = x << 1; end
                r = x;
            end
            4'h3: begin
                for (int k = 0; k < amt; k++) begin cc = x[0]; x = x >> 1; end
                r = x;
            end
            4'h4: begin
                for (int k = 0; k < amt; k++) begin cc = x[0]; x = {x[31], x[31:1]}; end
                r = x;
            end
            default: begin
                for (int k = 0; k < amt; k++) x = {x[0], x[31:1]};
                if (amt > 0) cc = x[31];
                r = x;
            end
        endcase
        nn = r[31];
        zz = (r == 32'h0);
    endtask

    function automatic string op_tag(logic [3:0] op, logic [7:0] amt);
        case (op)
            4'h0, 4'h1, 4'hC, 4'hE, 4'hF: return "R1";
            4'h5, 4'h6:                   return "R2";
            4'h8, 4'hA, 4'hB:             return "R3";
            4'h9:                         return "R4";
            4'hD:                         return "R5";
            4'h2, 4'h3:                   return (amt == 0) ? "R6" : "R7";
            4'h4:                         return (amt == 0) ? "R6" : "R8";
            default:                      return (amt == 0) ? "R6" : "R9";
        endcase
    endfunction

    task automatic check_val(input string tag, input string what, input logic [32:0] act,
                             input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s,
                         input logic c, input logic v);
        logic [31:0] er;
        logic ewe, en, ez, ec, ev;
        string cv_tag;
        @(posedge clk);
        op_code <= op; opnd_d <= d; opnd_s <= s; c_in <= c; v_in <= v;
        @(negedge clk);
        ref_model(op, d, s, c, v, er, ewe, en, ez, ec, ev);
        check_val(op_tag(op, s[7:0]), "we,result", {result_we, result}, {ewe, er});
        check_val("R10", "N,Z", {31'h0, n_out, z_out}, {31'h0, en, ez});
        cv_tag = (op inside {4'h0, 4'h1, 4'hC, 4'hE, 4'hF, 4'h8, 4'hD}) ? "R11"
                 : op_tag(op, s[7:0]);
        check_val(cv_tag, "C,V", {31'h0, c_out, v_out}, {31'h0, ec, ev});
    endtask

    task automatic run_all();
        logic [31:0] tmp, s;
        // Reset phase: all-zero inputs select AND of zeros.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R1", "reset we,result", {result_we, result}, {1'b1, 32'h0});
        check_val("R10", "reset N,Z", {31'h0, n_out, z_out}, {31'h0, 1'b0, 1'b1});
        rst = 1'b0;

        // R1 bitwise
        apply(4'h0, 32'hFF00_FF00, 32'h0F0F_0F0F, 1, 1);
        apply(4'h1, 32'h1234_5678, 32'h1234_5678, 0, 1);
        apply(4'hC, 32'h8000_0000, 32'h0000_0001, 1, 0);
        apply(4'hE, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 0, 0);
        apply(4'hF, 32'hDEAD_BEEF, 32'h0000_0000, 1, 1);
        // R2 add/subtract with carry
        apply(4'h5, 32'h7FFF_FFFF, 32'h0, 1, 0);
        apply(4'h5, 32'hFFFF_FFFF, 32'h1, 0, 1);
        apply(4'h6, 32'h5, 32'h5, 0, 0);
        apply(4'h6, 32'h5, 32'h5, 1, 1);
        apply(4'h6, 32'h8000_0000, 32'h1, 1, 0);
        // R3 flag-only
        apply(4'h8, 32'hF0F0_0000, 32'h0F0F_FFFF, 0, 1);
        apply(4'hA, 32'h42, 32'h42, 0, 0);
        apply(4'hA, 32'h1, 32'h2, 1, 0);
        apply(4'hB, 32'hFFFF_FFFF, 32'h1, 0, 1);
        // R4 negate
        apply(4'h9, 32'h1234, 32'h0, 0, 1);
        apply(4'h9, 32'h0, 32'h8000_0000, 0, 0);
        apply(4'h9, 32'h0, 32'h1, 1, 1);
        // R5 multiply
        apply(4'hD, 32'h0001_0000, 32'h0001_0000, 1, 1);
        apply(4'hD, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1);
        apply(4'hD, 32'h0000_1234, 32'h0000_0100, 1, 0);
        // R6 zero amount, upper source bits ignored
        apply(4'h2, 32'h8000_0001, 32'h0000_0100, 1, 0);
        apply(4'h3, 32'h8000_0001, 32'hFFFF_FF00, 0, 1);
        apply(4'h4, 32'h8000_0001, 32'h0000_0000, 1, 1);
        apply(4'h7, 32'h8000_0001, 32'h1234_5600, 0, 0);
        // R7 logical shift boundaries
        apply(4'h2, 32'h4000_0001, 32'h1, 0, 0);
        apply(4'h2, 32'h0000_0003, 32'd31, 0, 0);
        apply(4'h2, 32'h0000_0001, 32'd32, 0, 1);
        apply(4'h2, 32'hFFFF_FFFF, 32'hFFFF_FF21, 1, 0);
        apply(4'h3, 32'h8000_0000, 32'd32, 0, 0);
        apply(4'h3, 32'hFFFF_FFFF, 32'd33, 1, 1);
        apply(4'h3, 32'h0000_0003, 32'd1, 0, 0);
        // R8 arithmetic shift
        apply(4'h4, 32'h8000_0000, 32'd31, 0, 0);
        apply(4'h4, 32'h8000_0000, 32'd32, 0, 0);
        apply(4'h4, 32'h9000_0000, 32'd200, 0, 1);
        apply(4'h4, 32'h7FFF_FFFF, 32'd255, 1, 0);
        // R9 rotate
        apply(4'h7, 32'h8000_0001, 32'd32, 0, 0);
        apply(4'h7, 32'h0000_000F, 32'd4, 0, 1);
        apply(4'h7, 32'h0000_000F, 32'd36, 1, 0);
        apply(4'h7, 32'h0000_0001, 32'd64, 1, 0);

        // Random mix with shift-amount bias
        for (int i = 0; i < 3000; i++) begin
            tmp = $urandom;
            case ($urandom_range(0, 3))
                0: s = $urandom;
                1: s = {tmp[31:8], 8'($urandom_range(0, 40))};
                2: s = {24'h0, 8'($urandom_range(0, 255))};
                default: s = ($urandom_range(0, 1) == 0) ? 32'h8000_0000 : 32'h0;
            endcase
            apply(4'($urandom_range(0, 15)), $urandom, s, 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)));
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule